// File: doc/BRIEF.md
# Serial Command/Parameter Word Receiver

This block is the write-side slave of a three-wire serial link made up of an active-low chip select, a serial clock and one data line. Each transfer unit is a 9-bit word. The first bit is a kind flag, and the eight data bits follow it MSB first. The block keeps track of which command is open. It emits a one-cycle strobe for every complete command byte. For every complete parameter (or pixel) byte it emits a one-cycle commit strobe that carries the open command, the parameter's position within that command, and the byte itself. Register storage and any read path sit downstream.

All three link pins are brought into the system clock domain through a synchronizer and sampled by edge detection. The serial clock can therefore stop at any level between words. A static mode pin picks which serial-clock edge captures data.

Interrupted transfers follow two rules. If the chip select rises before a word is complete, the partial bits are dropped and the command context is left alone. If the chip select rises between words, nothing is lost, and the next word continues the stream.

The outputs have a valid strobe and no ready. The link has no way to stall the host, so the consumer must accept every strobe in the cycle it appears. Strobes come at most once every nine serial-clock periods.

Top module: `serial_cmd_rx`

## Requirements
- R1: While reset is asserted and right after it is released, `cmd_valid` and `prm_valid` are low and every output field reads 0.
- R2: A word is captured as 9 consecutive sampled bits while `cs_n` is low. The first bit is the kind flag, followed by data bits 7 down to 0. A flag of 0 makes a command: `cmd_valid` pulses and `cmd_byte` holds the 8 data bits.
- R3: A flag of 1 makes a parameter. `prm_valid` pulses with `prm_byte` equal to the data bits and `prm_cmd` equal to the most recent command byte (0 if no command has arrived since reset).
- R4: With `fall_edge` = 0, bits are sampled on rising `sclk` edges. With `fall_edge` = 1, they are sampled on falling edges. The edge of the other polarity has no effect.
- R5: `prm_idx` is 0 for the first parameter after a command and grows by one with each completed parameter. It holds at 2^IDX_W-1 once it reaches that value.
- R6: If `cs_n` rises after fewer than 9 bits, no strobe is raised. After the next falling `cs_n`, capture restarts at the first bit of a word. The open command and the index are unchanged.
- R7: If `cs_n` rises between complete words, the command and index context are kept. This holds for command→command, command→parameter, parameter→command and parameter→parameter.
- R8: When a multi-parameter command is broken inside a parameter and a new command follows, only the completed parameters are committed. The new command restarts the index at 0.
- R9: `sclk` and `sdata` activity while `cs_n` is high produces no strobe and does not advance bit capture.
- R10: Each strobe lasts one cycle, and `cmd_valid` and `prm_valid` are never high together.
- R11: Asserting `rst_n` in the middle of a word discards the partial word and clears the command and index context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Link select, active low |
| sclk | input | 1 | Serial clock from host, not free-running |
| sdata | input | 1 | Serial data from host |
| fall_edge | input | 1 | Capture edge: 0 rising, 1 falling; change only while `cs_n` is high |
| cmd_valid | output | 1 | One-cycle strobe for a completed command word |
| cmd_byte | output | 8 | Command byte, valid with `cmd_valid` |
| prm_valid | output | 1 | One-cycle commit strobe for a completed parameter word |
| prm_cmd | output | 8 | Command that owns the parameter |
| prm_idx | output | IDX_W | Position of the parameter within its command |
| prm_byte | output | 8 | Parameter byte |

## Verification
The stimulus includes unbroken command-plus-parameter bursts with all-zero and all-one bytes, which separate flag decoding from data ordering. Chip-select pauses at each of the four word-boundary pairings show that context is kept. Mid-word breaks inside a command, inside a parameter, and before a new command show that partial words are rolled back without disturbing the index. Serial-clock toggling with the link deselected, the falling-edge capture mode, and a run of more than 256 parameters each isolate a different property: edge gating, polarity selection and index saturation. A reset in mid-word separates the bit counter's rollback from the clearing of the context.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = BYTE_W + 1;

  typedef enum logic {
    KIND_CMD = 1'b0,
    KIND_PRM = 1'b1
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [BYTE_W-1:0] payload;
  } word_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // STAGES must be 2 or more
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/srx_edge.sv
module srx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic fall_mode,
  input  logic cs_act,
  output logic sample
);
  logic sclk_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  assign rise   = sclk_s & ~sclk_q;
  assign fall   = ~sclk_s & sclk_q;
  assign sample = cs_act & (fall_mode ? fall : rise);
endmodule

// File: rtl/srx_assemble.sv
module srx_assemble
  import srx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_act,
  input  logic  sample,
  input  logic  bit_in,
  output word_t word,
  output logic  word_vld
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-2:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;                 // partial word dropped
      end else if (sample) begin
        if (bit_cnt == LAST) begin
          word     <= word_t'({shreg, bit_in});
          word_vld <= 1'b1;
          bit_cnt  <= '0;
        end else begin
          shreg   <= {shreg[WORD_W-3:0], bit_in};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/srx_context.sv
module srx_context
  import srx_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  word_t             word,
  input  logic              word_vld,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              prm_valid,
  output logic [BYTE_W-1:0] prm_cmd,
  output logic [IDX_W-1:0]  prm_idx,
  output logic [BYTE_W-1:0] prm_byte
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic [BYTE_W-1:0] cur_cmd;
  logic [IDX_W-1:0]  nxt_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_cmd   <= '0;
      nxt_idx   <= '0;
      cmd_valid <= 1'b0;
      cmd_byte  <= '0;
      prm_valid <= 1'b0;
      prm_cmd   <= '0;
      prm_idx   <= '0;
      prm_byte  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      prm_valid <= 1'b0;
      if (word_vld) begin
        if (word.kind == KIND_CMD) begin
          cur_cmd   <= word.payload;
          nxt_idx   <= '0;
          cmd_valid <= 1'b1;
          cmd_byte  <= word.payload;
        end else begin
          prm_valid <= 1'b1;
          prm_cmd   <= cur_cmd;
          prm_idx   <= nxt_idx;
          prm_byte  <= word.payload;
          if (nxt_idx != IDX_MAX) nxt_idx <= nxt_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import srx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDX_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              fall_edge,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              prm_valid,
  output logic [BYTE_W-1:0] prm_cmd,
  output logic [IDX_W-1:0]  prm_idx,
  output logic [BYTE_W-1:0] prm_byte
);
  logic [2:0] pins_s;
  logic       cs_act, sample, word_vld;
  word_t      word;

  srx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdata}), .q(pins_s)
  );

  assign cs_act = ~pins_s[2];

  srx_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sclk_s(pins_s[1]), .fall_mode(fall_edge),
    .cs_act(cs_act), .sample(sample)
  );

  srx_assemble u_asm (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sample(sample),
    .bit_in(pins_s[0]), .word(word), .word_vld(word_vld)
  );

  srx_context #(.IDX_W(IDX_W)) u_ctx (
    .clk(clk), .rst_n(rst_n), .word(word), .word_vld(word_vld),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .prm_valid(prm_valid),
    .prm_cmd(prm_cmd), .prm_idx(prm_idx), .prm_byte(prm_byte)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDX_W       = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             cmd_valid,
  input logic [7:0]       cmd_byte,
  input logic             prm_valid,
  input logic [7:0]       prm_cmd,
  input logic [IDX_W-1:0] prm_idx
);
  localparam int unsigned QUIET = SYNC_STAGES + 3;
  localparam int unsigned QW    = $clog2(QUIET + 1);
  localparam logic [IDX_W-1:0] IMAX = {IDX_W{1'b1}};

  logic [7:0]       m_cmd;
  logic [IDX_W-1:0] m_idx;
  logic [QW-1:0]    hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd  <= '0;
      m_idx  <= '0;
      hi_cnt <= '0;
    end else begin
      if (cmd_valid) begin
        m_cmd <= cmd_byte;
        m_idx <= '0;
      end else if (prm_valid && m_idx != IMAX) begin
        m_idx <= m_idx + 1'b1;
      end
      if (!cs_n)                     hi_cnt <= '0;
      else if (hi_cnt != QW'(QUIET)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  p_one_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && prm_valid));
  p_cmd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  p_prm_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prm_valid |=> !prm_valid);
  p_idx_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prm_valid |-> prm_idx == m_idx);
  p_owner_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prm_valid |-> prm_cmd == m_cmd);
  p_quiet_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cnt == QW'(QUIET)) |-> (!cmd_valid && !prm_valid));
endmodule

bind serial_cmd_rx srx_checker #(.SYNC_STAGES(SYNC_STAGES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_valid(cmd_valid),
  .cmd_byte(cmd_byte), .prm_valid(prm_valid), .prm_cmd(prm_cmd),
  .prm_idx(prm_idx)
);

// File: tb/sim_serial_cmd_rx.sv
module sim_serial_cmd_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sclk = 1'b0, sdata = 1'b0, fall_edge = 1'b0;
  logic       cmd_valid, prm_valid;
  logic [7:0] cmd_byte, prm_cmd, prm_byte, prm_idx;

  int n_run = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  string       cur_tag = "R1";
  int          m_cmd = 0, m_idx = 0;
  bit          mon_on = 1'b0;
  bit          done = 1'b0;

  serial_cmd_rx u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdata(sdata),
    .fall_edge(fall_edge), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .prm_valid(prm_valid), .prm_cmd(prm_cmd), .prm_idx(prm_idx),
    .prm_byte(prm_byte)
  );

  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // model: entry = {kind[24], cmd[23:16], idx[15:8], byte[7:0]}
  function automatic void model_word(input logic dc, input logic [7:0] b);
    if (!dc) begin
      exp_q.push_back({7'd0, 1'b0, 8'd0, 8'd0, b});
      m_cmd = b;
      m_idx = 0;
    end else begin
      exp_q.push_back({7'd0, 1'b1, m_cmd[7:0], m_idx[7:0], b});
      if (m_idx < 255) m_idx++;
    end
    tag_q.push_back(cur_tag);
  endfunction

  task automatic send(input logic dc, input logic [7:0] b, input int nbits);
    logic [8:0] w = {dc, b};
    for (int i = 0; i < nbits; i++) begin
      sdata = w[8-i];
      tick(4);
      if (i == 8) model_word(dc, b);
      sclk = ~sclk;      // capture edge
      tick(4);
      sclk = ~sclk;
    end
  endtask

  task automatic cs(input logic v);
    cs_n = v;
    tick(4);
  endtask

  task automatic settle();
    tick(12);
    n_run++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s: pending strobes actual=%0d expected=0", cur_tag, exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  task automatic check_idle(input string t);
    n_run++;
    if (cmd_valid || prm_valid || cmd_byte != 0 || prm_cmd != 0 || prm_idx != 0 || prm_byte != 0) begin
      n_fail++;
      $display("FAIL %s: outputs actual=%b%b/%h/%h/%h/%h expected=all zero", t,
               cmd_valid, prm_valid, cmd_byte, prm_cmd, prm_idx, prm_byte);
    end
  endtask

  // compared on every clock: any strobe must match the model's next entry
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (cmd_valid && prm_valid) begin
        n_run++; n_fail++;
        $display("FAIL R10: both strobes actual=11 expected=one");
      end else if (cmd_valid || prm_valid) begin
        logic [31:0] act;
        act = cmd_valid ? {7'd0, 1'b0, 8'd0, 8'd0, cmd_byte}
                        : {7'd0, 1'b1, prm_cmd, prm_idx, prm_byte};
        n_run++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL %s: unexpected strobe actual=%h expected=none", cur_tag, act);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (act != e) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", t, act, e);
          end
        end
      end
    end
  end

  initial begin
    #(150000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL R1: watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    check_idle("R1");
    rst_n = 1'b1;
    tick(6);
    check_idle("R1");
    mon_on = 1'b1;

    // R2 R3: unbroken burst, zero and ones bytes
    cur_tag = "R2";
    cs(1'b0);
    send(1'b0, 8'h2C, 9);
    cur_tag = "R3";
    send(1'b1, 8'hA5, 9);
    send(1'b1, 8'h5A, 9);
    send(1'b1, 8'hFF, 9);
    cur_tag = "R2";
    send(1'b0, 8'h00, 9);
    cur_tag = "R3";
    send(1'b1, 8'h00, 9);
    cs(1'b1);
    settle();

    // R9: activity while deselected
    cur_tag = "R9";
    for (int k = 0; k < 20; k++) begin
      sdata = k[0];
      tick(3);
      sclk = ~sclk;
      tick(3);
    end
    settle();
    cs(1'b0);
    send(1'b0, 8'h3A, 9);
    send(1'b1, 8'h55, 9);
    cs(1'b1);
    settle();

    // R6: break inside parameter, then inside a command
    cur_tag = "R6";
    cs(1'b0);
    send(1'b0, 8'hB0, 9);
    send(1'b1, 8'h11, 9);
    send(1'b1, 8'h22, 5);
    cs(1'b1);
    cs(1'b0);
    send(1'b1, 8'h22, 9);
    send(1'b0, 8'h77, 4);
    cs(1'b1);
    cs(1'b0);
    send(1'b1, 8'h33, 9);
    cs(1'b1);
    settle();

    // R7: pauses at all four word boundaries
    cur_tag = "R7";
    cs(1'b0); send(1'b0, 8'h10, 9); cs(1'b1);
    cs(1'b0); send(1'b0, 8'h11, 9); cs(1'b1);
    cs(1'b0); send(1'b1, 8'h01, 9); cs(1'b1);
    cs(1'b0); send(1'b1, 8'h02, 9); cs(1'b1);
    cs(1'b0); send(1'b0, 8'h12, 9); cs(1'b1);
    settle();

    // R8: broken multi-parameter command followed by a new command
    cur_tag = "R8";
    cs(1'b0);
    send(1'b0, 8'hE0, 9);
    send(1'b1, 8'h01, 9);
    send(1'b1, 8'h02, 9);
    send(1'b1, 8'h03, 3);
    cs(1'b1);
    cs(1'b0);
    send(1'b0, 8'hE1, 9);
    send(1'b1, 8'h09, 9);
    cs(1'b1);
    settle();

    // R4: falling-edge capture
    cur_tag = "R4";
    fall_edge = 1'b1;
    sclk = 1'b1;
    tick(6);
    cs(1'b0);
    send(1'b0, 8'h5C, 9);
    send(1'b1, 8'hC3, 9);
    send(1'b1, 8'h81, 9);
    cs(1'b1);
    settle();
    fall_edge = 1'b0;
    sclk = 1'b0;
    tick(6);

    // R5: index runs past its maximum and restarts on a command
    cur_tag = "R5";
    cs(1'b0);
    send(1'b0, 8'h2B, 9);
    for (int k = 0; k < 258; k++) send(1'b1, k[7:0], 9);
    send(1'b0, 8'h2A, 9);
    send(1'b1, 8'h6E, 9);
    cs(1'b1);
    settle();

    // R11: reset in the middle of a word
    cur_tag = "R11";
    cs(1'b0);
    send(1'b0, 8'h44, 9);
    send(1'b1, 8'h01, 9);
    send(1'b1, 8'h66, 6);
    tick(8);
    rst_n = 1'b0;
    exp_q.delete();
    tag_q.delete();
    m_cmd = 0;
    m_idx = 0;
    tick(3);
    check_idle("R11");
    rst_n = 1'b1;
    tick(6);
    send(1'b1, 8'h77, 9);
    cs(1'b1);
    settle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule